// File: doc/BRIEF.md
# Temperature Sensor Register File with Threshold Alarm

This block holds the register side of a single-wire temperature sensor. A conversion strobe loads a 16-bit signed temperature (two's complement, 1/16-degree steps) into a scratchpad. The scratchpad also holds a high alarm limit, a low alarm limit and a configuration byte. After each conversion the integer part of the new reading is compared against the two limits, and the result sets or clears an alarm flag.

The host reads the scratchpad one byte at a time by index. Index 8 returns a CRC-8 computed over the eight scratchpad bytes. The three writable bytes are updated one byte at a time. A write is accepted only when it forms a complete sequence: high limit, then low limit, then configuration. Only a complete sequence can be copied into the shadow non-volatile store. A recall pulse reloads the scratchpad from that store, and so does a power-on reset. A bus reset discards a sequence that is only partly written.

Top module: `thermo_scratch`

## Requirements
- R1: After `rst`, the scratchpad is set as follows. The temperature is 0x0550. The high limit, low limit and configuration bytes hold the values in the shadow store, which starts at 0x4B, 0x46 and 0x7F. `alarm` is 0 and `wr_valid` is 0.
- R2: `rd_data` is registered and returns the byte selected by `rd_idx` one cycle after `rd_idx` is applied. The index map is: 0 = temperature bits 7:0, 1 = temperature bits 15:8, 2 = high limit, 3 = low limit, 4 = configuration.
- R3: Indices 5 to 7 and 9 to 15 always read 0xFF. A write with `wr_sel` = 3 changes no byte and does not change the write-sequence progress.
- R4: Index 8 reads the CRC-8 of bytes 0 to 7. The CRC uses polynomial x^8+x^5+x^4+1 and starts from 0. Bytes are fed from byte 0 to byte 7, and each byte is fed least significant bit first. This is the same as a right-shifting register that XORs 0x8C when the bit shifted out, XORed with the data bit, is 1.
- R5: A `conv_done` pulse stores `conv_temp`. The new value is readable from the next cycle.
- R6: On `conv_done`, `alarm` becomes 1 in the next cycle when the signed value of `conv_temp[11:4]` is greater than the signed high limit. The fraction bits 3:0 have no effect on the comparison.
- R7: On `conv_done`, `alarm` becomes 1 when the integer part is less than the signed low limit. It becomes 0 when the integer part is within the limits, including when it equals either limit.
- R8: `alarm` changes only on `conv_done`. Writing new limits leaves it unchanged until the next conversion.
- R9: `wr_sel` selects the target byte: 0 = high limit, 1 = low limit, 2 = configuration. `wr_valid` rises one cycle after a configuration write that directly follows a low write, which itself directly follows a high write. A high write always restarts the sequence. Any other order returns the sequence to its start.
- R10: When `copy_req` arrives while `wr_valid` is 1, bytes 2 to 4 are copied into the shadow store and `wr_valid` clears. When `copy_req` arrives while `wr_valid` is 0, nothing happens.
- R11: `recall_req` reloads bytes 2 to 4 from the shadow store, clears the sequence, and ignores a write in the same cycle.
- R12: `bus_rst` with an incomplete sequence reloads bytes 2 to 4 from the shadow store and clears the sequence. With a complete sequence, it keeps the written bytes and `wr_valid` stays 1. Writes in a `bus_rst` cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_rst | input | 1 | Bus reset pulse; discards a partial write |
| conv_done | input | 1 | Conversion finished strobe |
| conv_temp | input | 16 | New temperature, two's complement, 1/16 degree |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Write target: 0 high, 1 low, 2 config, 3 none |
| wr_data | input | 8 | Write byte |
| copy_req | input | 1 | Copy limits and configuration to the shadow store |
| recall_req | input | 1 | Reload limits and configuration from the shadow store |
| rd_idx | input | 4 | Read byte index |
| rd_data | output | 8 | Registered read byte |
| alarm | output | 1 | Registered alarm flag |
| wr_valid | output | 1 | A complete write sequence is pending |

## Verification
Every result in this block appears exactly one clock edge after its cause: `rd_data` after an index change, `alarm` after `conv_done`, and `wr_valid` after the configuration write or a copy, recall or bus reset. The bench changes inputs on the falling edge and samples outputs on the next falling edge, so each check looks at the register loaded by the single rising edge in between. Effects of a copy are observed through a later recall, which takes one more edge.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  typedef enum logic [1:0] {
    SEL_HIGH = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HIGH = 2'd1,
    SQ_LOW  = 2'd2,
    SQ_DONE = 2'd3
  } seq_e;

  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;
endpackage

// File: rtl/thermo_crc8.sv
module thermo_crc8
  import thermo_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int BYTE_W = 8
) (
  input  logic [NBYTES*BYTE_W-1:0] data,
  output logic [CRC_W-1:0]         crc
);
  localparam int NBITS = NBYTES * BYTE_W;

  // One bit-serial stage per input bit, fed LSB of byte 0 first.
  logic [CRC_W-1:0] chain [NBITS+1];
  assign chain[0] = '0;

  for (genvar g = 0; g < NBITS; g++) begin : g_stage
    logic fb;
    assign fb = chain[g][0] ^ data[g];
    assign chain[g+1] = {1'b0, chain[g][CRC_W-1:1]} ^ (fb ? CRC_POLY_REFL : '0);
  end

  assign crc = chain[NBITS];
endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [BYTE_W-1:0] t_int,
  input  logic [BYTE_W-1:0] th_high,
  input  logic [BYTE_W-1:0] th_low,
  output logic              alarm
);
  logic signed [BYTE_W-1:0] t_s, hi_s, lo_s;
  logic over, under;

  assign t_s   = $signed(t_int);
  assign hi_s  = $signed(th_high);
  assign lo_s  = $signed(th_low);
  assign over  = t_s > hi_s;
  assign under = t_s < lo_s;

  always_ff @(posedge clk) begin
    if (rst)            alarm <= 1'b0;
    else if (conv_done) alarm <= over | under;
  end

  p_alarm_high_r6: assert property (@(posedge clk) disable iff (rst)
    conv_done && ($signed(t_int) > $signed(th_high)) |=> alarm);
  p_alarm_inside_r7: assert property (@(posedge clk) disable iff (rst)
    conv_done && ($signed(t_int) <= $signed(th_high)) && ($signed(t_int) >= $signed(th_low))
    |=> !alarm);
  p_alarm_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(alarm));
endmodule

// File: rtl/thermo_wrseq.sv
module thermo_wrseq
  import thermo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       hold,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  output logic       complete
);
  seq_e st, st_nx;

  always_comb begin
    st_nx = st;
    if (clear) begin
      st_nx = SQ_IDLE;
    end else if (wr_en && !hold) begin
      case (wsel_e'(wr_sel))
        SEL_HIGH: st_nx = SQ_HIGH;
        SEL_LOW:  st_nx = (st == SQ_HIGH) ? SQ_LOW  : SQ_IDLE;
        SEL_CFG:  st_nx = (st == SQ_LOW)  ? SQ_DONE : SQ_IDLE;
        default:  st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= SQ_IDLE;
    else     st <= st_nx;
  end

  assign complete = (st == SQ_DONE);

  p_done_after_cfg_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(complete) |-> $past(wr_en && !hold && wr_sel == 2'd2));
  p_clear_drops_r11: assert property (@(posedge clk) disable iff (rst)
    clear |=> !complete);
endmodule

// File: rtl/thermo_scratch.sv
module thermo_scratch
  import thermo_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int TEMP_W   = 2 * BYTE_W,
  parameter int FRAC_W   = 4,
  parameter int SP_BYTES = 8,
  parameter int FIRST_RSVD = 5,
  parameter logic [TEMP_W-1:0] TEMP_RST     = 16'h0550,
  parameter logic [BYTE_W-1:0] NV_HIGH_INIT = 8'h4B,
  parameter logic [BYTE_W-1:0] NV_LOW_INIT  = 8'h46,
  parameter logic [BYTE_W-1:0] NV_CFG_INIT  = 8'h7F,
  parameter logic [BYTE_W-1:0] RSVD_BYTE    = 8'hFF
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                bus_rst,
  input  logic                                conv_done,
  input  logic [TEMP_W-1:0]                   conv_temp,
  input  logic                                wr_en,
  input  logic [1:0]                          wr_sel,
  input  logic [BYTE_W-1:0]                   wr_data,
  input  logic                                copy_req,
  input  logic                                recall_req,
  input  logic [$clog2(SP_BYTES+1)-1:0]       rd_idx,
  output logic [BYTE_W-1:0]                   rd_data,
  output logic                                alarm,
  output logic                                wr_valid
);
  localparam int IDX_W = $clog2(SP_BYTES + 1);
  localparam int SEL_W = $clog2(SP_BYTES);
  localparam int INT_LO = FRAC_W;
  localparam int INT_HI = FRAC_W + BYTE_W - 1;
  localparam logic [IDX_W-1:0] CRC_IDX  = IDX_W'(SP_BYTES);
  localparam logic [IDX_W-1:0] RSVD_IDX = IDX_W'(FIRST_RSVD);

  // Volatile scratchpad state
  logic [TEMP_W-1:0] temp_q;
  logic [BYTE_W-1:0] sp_high, sp_low, sp_cfg;

  // Shadow non-volatile store: survives every reset, initial contents only
  logic [BYTE_W-1:0] nv_high = NV_HIGH_INIT;
  logic [BYTE_W-1:0] nv_low  = NV_LOW_INIT;
  logic [BYTE_W-1:0] nv_cfg  = NV_CFG_INIT;

  // Control decode
  logic do_copy, reload, seq_clear, wr_ok;
  assign do_copy   = copy_req && wr_valid && !recall_req;
  assign reload    = recall_req || (bus_rst && !wr_valid);
  assign seq_clear = recall_req || (bus_rst && !wr_valid) || (copy_req && wr_valid);
  assign wr_ok     = wr_en && !recall_req && !bus_rst;

  thermo_wrseq u_seq (
    .clk      (clk),
    .rst      (rst),
    .clear    (seq_clear),
    .hold     (bus_rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .complete (wr_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q  <= TEMP_RST;
      sp_high <= nv_high;
      sp_low  <= nv_low;
      sp_cfg  <= nv_cfg;
    end else begin
      if (conv_done) temp_q <= conv_temp;
      if (reload) begin
        sp_high <= nv_high;
        sp_low  <= nv_low;
        sp_cfg  <= nv_cfg;
      end else if (wr_ok) begin
        case (wsel_e'(wr_sel))
          SEL_HIGH: sp_high <= wr_data;
          SEL_LOW:  sp_low  <= wr_data;
          SEL_CFG:  sp_cfg  <= wr_data;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && do_copy) begin
      nv_high <= sp_high;
      nv_low  <= sp_low;
      nv_cfg  <= sp_cfg;
    end
  end

  // Scratchpad byte view
  logic [BYTE_W-1:0] sp [SP_BYTES];
  logic [SP_BYTES*BYTE_W-1:0] sp_flat;
  logic [CRC_W-1:0] crc;

  assign sp[0] = temp_q[BYTE_W-1:0];
  assign sp[1] = temp_q[TEMP_W-1:BYTE_W];
  assign sp[2] = sp_high;
  assign sp[3] = sp_low;
  assign sp[4] = sp_cfg;
  for (genvar g = FIRST_RSVD; g < SP_BYTES; g++) begin : g_rsvd
    assign sp[g] = RSVD_BYTE;
  end
  for (genvar g = 0; g < SP_BYTES; g++) begin : g_flat
    assign sp_flat[g*BYTE_W +: BYTE_W] = sp[g];
  end

  thermo_crc8 #(.NBYTES(SP_BYTES), .BYTE_W(BYTE_W)) u_crc (
    .data (sp_flat),
    .crc  (crc)
  );

  thermo_alarm #(.BYTE_W(BYTE_W)) u_alarm (
    .clk       (clk),
    .rst       (rst),
    .conv_done (conv_done),
    .t_int     (conv_temp[INT_HI:INT_LO]),
    .th_high   (sp_high),
    .th_low    (sp_low),
    .alarm     (alarm)
  );

  // Registered read port; the data path carries no reset
  always_ff @(posedge clk) begin
    if (rd_idx < CRC_IDX)       rd_data <= sp[rd_idx[SEL_W-1:0]];
    else if (rd_idx == CRC_IDX) rd_data <= crc;
    else                        rd_data <= RSVD_BYTE;
  end

  p_rsvd_read_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_idx >= RSVD_IDX && rd_idx < CRC_IDX) |=> rd_data == RSVD_BYTE);
  p_conv_load_r5: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> temp_q == $past(conv_temp));
  p_copy_clears_r10: assert property (@(posedge clk) disable iff (rst)
    copy_req && wr_valid |=> !wr_valid);
  p_recall_r11: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> {sp_high, sp_low, sp_cfg} == $past({nv_high, nv_low, nv_cfg}));
  p_bus_rst_keep_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rst && wr_valid && !recall_req && !copy_req |=> wr_valid);
endmodule

// File: tb/thermo_scratch_bench.sv
module thermo_scratch_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, bus_rst, conv_done, wr_en, copy_req, recall_req;
  logic [15:0] conv_temp;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data, rd_data;
  logic [3:0]  rd_idx;
  logic        alarm, wr_valid;

  thermo_scratch u_thermo_scratch (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .conv_done(conv_done),
    .conv_temp(conv_temp), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .copy_req(copy_req), .recall_req(recall_req), .rd_idx(rd_idx),
    .rd_data(rd_data), .alarm(alarm), .wr_valid(wr_valid)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] m_t;
  logic [7:0]  m_h, m_l, m_c, n_h, n_l, n_c;

  // {temperature, high limit, low limit, expected alarm}
  localparam logic [32:0] VECS [9] = '{
    {16'h0190, 8'h1E, 8'h0A, 1'b0},
    {16'h01F0, 8'h1E, 8'h0A, 1'b1},
    {16'h01E8, 8'h1E, 8'h0A, 1'b0},
    {16'h00A0, 8'h1E, 8'h0A, 1'b0},
    {16'h009F, 8'h1E, 8'h0A, 1'b1},
    {16'hFF5E, 8'h1E, 8'hF6, 1'b1},
    {16'hFF60, 8'h1E, 8'hF6, 1'b0},
    {16'h07D0, 8'h7C, 8'h80, 1'b1},
    {16'hFC90, 8'h7C, 8'h80, 1'b0}
  };

  function automatic logic [7:0] crc_ref(input logic [63:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 64; i++) begin
      logic b = c[0] ^ d[i];
      c = c >> 1;
      if (b) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk1(); @(negedge clk); endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] val);
    rd_idx = idx; clk1(); val = rd_data;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; clk1(); wr_en = 0;
    if (sel == 2'd0) m_h = d; else if (sel == 2'd1) m_l = d; else if (sel == 2'd2) m_c = d;
  endtask

  task automatic wr_full(input logic [7:0] h, input logic [7:0] l, input logic [7:0] c);
    wr(2'd0, h); wr(2'd1, l); wr(2'd2, c);
  endtask

  task automatic conv(input logic [15:0] t);
    conv_done = 1; conv_temp = t; clk1(); conv_done = 0; m_t = t;
  endtask

  task automatic check_limits(input string req);
    logic [7:0] v;
    rd(4'd2, v); chk(req, v, m_h);
    rd(4'd3, v); chk(req, v, m_l);
    rd(4'd4, v); chk(req, v, m_c);
  endtask

  task automatic check_crc();
    logic [7:0] v;
    rd(4'd8, v);
    chk("R4 crc", v, crc_ref({24'hFFFFFF, m_c, m_l, m_h, m_t}));
  endtask

  task automatic recall();
    recall_req = 1; clk1(); recall_req = 0;
    m_h = n_h; m_l = n_l; m_c = n_c;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1; bus_rst = 0; conv_done = 0; conv_temp = 0; wr_en = 0; wr_sel = 0;
    wr_data = 0; copy_req = 0; recall_req = 0; rd_idx = 0;
    m_t = 16'h0550; n_h = 8'h4B; n_l = 8'h46; n_c = 8'h7F;
    m_h = n_h; m_l = n_l; m_c = n_c;
    repeat (3) clk1();
    rst = 0;

    // R1 reset state
    chk("R1 alarm", {7'd0, alarm}, 8'd0);
    chk("R1 wr_valid", {7'd0, wr_valid}, 8'd0);
    rd(4'd0, v); chk("R1 temp lsb", v, 8'h50);
    rd(4'd1, v); chk("R1 temp msb", v, 8'h05);
    check_limits("R1 limits");
    // R3 reserved indices
    foreach (VECS[i]) if (i < 3) begin rd(4'(5 + i), v); chk("R3 reserved", v, 8'hFF); end
    rd(4'd9, v);  chk("R3 above crc", v, 8'hFF);
    rd(4'd15, v); chk("R3 top index", v, 8'hFF);
    check_crc();

    // Table walk: R2 R4 R5 R6 R7 R9
    for (int i = 0; i < 9; i++) begin
      logic [32:0] e = VECS[i];
      wr_full(e[16:9], e[8:1], 8'(8'h1F + i));
      chk("R9 full sequence", {7'd0, wr_valid}, 8'd1);
      conv(e[32:17]);
      chk("R6 R7 alarm", {7'd0, alarm}, {7'd0, e[0]});
      rd(4'd0, v); chk("R5 temp lsb", v, e[24:17]);
      rd(4'd1, v); chk("R5 temp msb", v, e[32:25]);
      check_limits("R2 limits");
      check_crc();
    end

    // R8 alarm held until next conversion
    wr_full(8'h1E, 8'h0A, 8'h1F);
    conv(16'h01F0);
    chk("R8 alarm set", {7'd0, alarm}, 8'd1);
    wr_full(8'h40, 8'h00, 8'h1F);
    chk("R8 alarm held", {7'd0, alarm}, 8'd1);
    conv(16'h01F0);
    chk("R8 alarm reeval", {7'd0, alarm}, 8'd0);

    // R9 ordering
    wr(2'd0, 8'h01); chk("R9 high only", {7'd0, wr_valid}, 8'd0);
    wr(2'd1, 8'h02); wr(2'd1, 8'h03); wr(2'd2, 8'h04);
    chk("R9 low twice", {7'd0, wr_valid}, 8'd0);
    wr(2'd0, 8'h05); wr(2'd2, 8'h06);
    chk("R9 skipped low", {7'd0, wr_valid}, 8'd0);
    wr_full(8'hA1, 8'hB2, 8'hC3);
    chk("R9 complete", {7'd0, wr_valid}, 8'd1);
    wr_en = 1; wr_sel = 2'd3; wr_data = 8'h99; clk1(); wr_en = 0;
    chk("R3 sel none valid", {7'd0, wr_valid}, 8'd1);
    check_limits("R3 sel none bytes");

    // R10 copy, R11 recall
    copy_req = 1; clk1(); copy_req = 0;
    n_h = m_h; n_l = m_l; n_c = m_c;
    chk("R10 copy clears", {7'd0, wr_valid}, 8'd0);
    wr(2'd0, 8'h99);
    recall();
    chk("R11 recall valid", {7'd0, wr_valid}, 8'd0);
    check_limits("R11 recall bytes");
    wr(2'd0, 8'h12);
    copy_req = 1; clk1(); copy_req = 0;
    recall();
    check_limits("R10 copy ignored");
    wr_full(8'h01, 8'h02, 8'h03);
    recall();
    chk("R11 clears complete", {7'd0, wr_valid}, 8'd0);
    check_limits("R11 reload");

    // R12 bus reset
    wr(2'd0, 8'h55); wr(2'd1, 8'h66);
    bus_rst = 1; clk1(); bus_rst = 0;
    m_h = n_h; m_l = n_l; m_c = n_c;
    check_limits("R12 partial dropped");
    chk("R12 partial valid", {7'd0, wr_valid}, 8'd0);
    wr_full(8'h0F, 8'hF0, 8'h3C);
    bus_rst = 1; clk1(); bus_rst = 0;
    chk("R12 complete kept", {7'd0, wr_valid}, 8'd1);
    check_limits("R12 complete bytes");
    copy_req = 1; clk1(); copy_req = 0;
    n_h = m_h; n_l = m_l; n_c = m_c;

    // R1 power-on reset reload from updated store
    wr_full(8'h77, 8'h88, 8'h99);
    conv(16'h07D0);
    rst = 1; clk1(); clk1(); rst = 0;
    m_h = n_h; m_l = n_l; m_c = n_c; m_t = 16'h0550;
    chk("R1 reset alarm", {7'd0, alarm}, 8'd0);
    chk("R1 reset valid", {7'd0, wr_valid}, 8'd0);
    check_limits("R1 reset reload");
    rd(4'd1, v); chk("R1 reset temp", v, 8'h05);
    check_crc();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule